// File: doc/BRIEF.md
# Masked-History ADC Output Corrector

This block sits behind a quantizer and cleans up its output stream one sample at a time. It keeps the last few accepted codes in a shift register. A fixed, build-time choice of bits taken from across that history is packed into a short table address. The address reads a precomputed estimate from an on-chip table, and the estimate comes out as a corrected code with the same width as the raw code. The table holds far fewer entries than a table indexed on every history bit would need.

The estimates are stored with a few extra fraction bits. A runtime mode picks one of three ways to apply dither. The table can hold values that already carry dither, and the block reads one bank. The block can pick one of several parallel banks at random for each lookup. It can also add a pseudo-random fraction to a single bank's estimate and then drop the fraction bits. The randomness comes from an 8-bit LFSR that is seeded while reset is held, so the sequence can be reproduced. Table contents are loaded through a simple synchronous write port. From the stored history, the table and the LFSR state to the output, the path is purely combinational.

Top module: `masked_hist_corrector`

## Requirements
- R1: With default parameters (4-bit codes, three codes of history, newest code in history bits 3:0, the one before in 7:4, the oldest in 11:8), the table index is {oldest[0], previous[3], newest[3:0]}. No other history bit has any effect on the output.
- R2: The history shifts in `in_code` only on a clock edge where `in_valid` is high. Otherwise it holds, whatever `in_code` is doing.
- R3: `out_valid` is 0 after reset and stays 0 until three valid samples have been accepted. From then on it stays 1 until the next reset.
- R4: A write with `tw_en` high stores `tw_data` (6 bits: 4 integer bits over 2 fraction bits) at bank `tw_bank`, index `tw_idx`, on the clock edge. Reads are combinational, so the stored value is visible right after that edge.
- R5: In mode 0, and also in mode 3, `out_code` is bits 5:2 of the bank 0 entry at the current index.
- R6: In mode 1, the bank is given by LFSR bit 0. `out_code` is bits 5:2 of that bank's entry.
- R7: In mode 2, the bank 0 entry plus LFSR bits 1:0, taken as an unsigned fraction, is reduced to bits 5:2. If the sum carries past 6 bits, the output saturates to 4'hF.
- R8: While `rst_n` is low, the LFSR loads `seed`, with a seed of zero replaced by 8'h01. After that it steps once per valid sample as next = {s[6:0], s[7]^s[5]^s[4]^s[3]} and holds otherwise.
- R9: No register lies between the stored state and `out_code`. A change of `dmode` shows at the output within the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Raw sample strobe |
| in_code | input | 4 | Raw quantizer code |
| dmode | input | 2 | Dither mode: 0 stored, 1 random bank, 2 added fraction, 3 as 0 |
| seed | input | 8 | LFSR seed, sampled while reset is low |
| tw_en | input | 1 | Table write enable |
| tw_bank | input | 1 | Table write bank |
| tw_idx | input | 6 | Table write index |
| tw_data | input | 6 | Table write estimate |
| out_code | output | 4 | Corrected code |
| out_valid | output | 1 | History is full and `out_code` is meaningful |

## Verification
The hardest case to reach is showing that unmasked history bits have no effect. It needs two histories that differ only in bits left out of the mask, and those bits sit in older samples that cannot be set directly. The bench feeds one three-sample sequence and records the result. It then feeds a second sequence whose older codes differ only in unmasked bits and compares the two outputs. Saturation in the added-fraction mode is reached by writing a near-full estimate at the live index. The zero-seed substitution is observed through the bank that random-bank mode selects right after reset.

// File: rtl/mhc_pkg.sv
package mhc_pkg;

    localparam int LFSR_W = 8;

    typedef enum logic [1:0] {
        DM_STORED = 2'd0,
        DM_BANKS  = 2'd1,
        DM_ADDED  = 2'd2,
        DM_SPARE  = 2'd3
    } dmode_e;

    // number of set bits of m strictly below position upto
    function automatic int ones_below(input logic [63:0] m, input int upto);
        int n;
        n = 0;
        for (int k = 0; k < 64; k++) begin
            if (k < upto && m[k]) n++;
        end
        return n;
    endfunction

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/mhc_history.sv
module mhc_history #(
    parameter int CODE_W = 4,
    parameter int DEPTH  = 3,
    parameter logic [CODE_W*DEPTH-1:0] MASK = 12'h18F,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_code,
    output logic [IDX_W-1:0]  idx_o,
    output logic              full_o
);
    localparam int HIST_W = CODE_W * DEPTH;
    localparam int FILL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [FILL_W-1:0] fill;
    } hstate_t;

    hstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.hist = {st_q.hist[HIST_W-CODE_W-1:0], in_code};
            if (st_q.fill != FILL_W'(DEPTH)) st_d.fill = st_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // pack the selected history bits, in ascending order, into the index
    for (genvar b = 0; b < HIST_W; b++) begin : g_pick
        if (MASK[b]) begin : g_on
            localparam int POS = mhc_pkg::ones_below(64'(MASK), b);
            assign idx_o[POS] = st_q.hist[b];
        end
    end

    assign full_o = (st_q.fill == FILL_W'(DEPTH));

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q.hist));
    a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |=> full_o);
    a_r3_fill_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(in_valid));

endmodule

// File: rtl/mhc_table.sv
module mhc_table #(
    parameter int IDX_W  = 6,
    parameter int EST_W  = 6,
    parameter int NBANK  = 2,
    parameter int BSEL_W = 1
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [BSEL_W-1:0]      wr_bank,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [EST_W-1:0]       wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [NBANK*EST_W-1:0] rd_flat
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [EST_W-1:0] mem_q [NBANK][ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_bank][wr_idx] <= wr_data;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign rd_flat[b*EST_W +: EST_W] = mem_q[b][rd_idx];
    end

endmodule

// File: rtl/mhc_dither.sv
module mhc_dither #(
    parameter int CODE_W = 4,
    parameter int EST_W  = 6,
    parameter int NBANK  = 2,
    parameter int BSEL_W = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        adv,
    input  logic [mhc_pkg::LFSR_W-1:0]  seed,
    input  logic [1:0]                  mode,
    input  logic [NBANK*EST_W-1:0]      rd_flat,
    output logic [CODE_W-1:0]           code_o
);
    import mhc_pkg::*;

    localparam int FRAC_W = EST_W - CODE_W;

    logic [LFSR_W-1:0] lfsr_d, lfsr_q, seed_fix;
    logic [EST_W-1:0]  entry;
    logic [EST_W:0]    sum;

    always_comb begin
        lfsr_d   = adv ? lfsr_step(lfsr_q) : lfsr_q;
        seed_fix = (seed == '0) ? LFSR_W'(1) : seed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= seed_fix;
        else        lfsr_q <= lfsr_d;
    end

    always_comb begin
        entry = rd_flat[EST_W-1:0];
        if (mode == DM_BANKS) begin
            for (int b = 0; b < NBANK; b++) begin
                if (BSEL_W'(b) == lfsr_q[BSEL_W-1:0]) entry = rd_flat[b*EST_W +: EST_W];
            end
        end
        sum = {1'b0, entry} + (EST_W+1)'(lfsr_q[FRAC_W-1:0]);
        if (mode == DM_ADDED) code_o = sum[EST_W] ? '1 : sum[EST_W-1:FRAC_W];
        else                  code_o = entry[EST_W-1:FRAC_W];
    end

    a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
    a_r8_lfsr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(lfsr_q));
    a_r7_added_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DM_ADDED) |-> (code_o >= rd_flat[EST_W-1:FRAC_W]));

endmodule

// File: rtl/masked_hist_corrector.sv
module masked_hist_corrector #(
    parameter int CODE_W = 4,
    parameter int DEPTH  = 3,
    parameter logic [CODE_W*DEPTH-1:0] MASK = 12'h18F,
    parameter int FRAC_W = 2,
    parameter int NBANK  = 2,
    localparam int HIST_W = CODE_W * DEPTH,
    localparam int IDX_W  = mhc_pkg::ones_below(64'(MASK), HIST_W),
    localparam int EST_W  = CODE_W + FRAC_W,
    localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [CODE_W-1:0]          in_code,
    input  logic [1:0]                 dmode,
    input  logic [mhc_pkg::LFSR_W-1:0] seed,
    input  logic                       tw_en,
    input  logic [BSEL_W-1:0]          tw_bank,
    input  logic [IDX_W-1:0]           tw_idx,
    input  logic [EST_W-1:0]           tw_data,
    output logic [CODE_W-1:0]          out_code,
    output logic                       out_valid
);
    logic [IDX_W-1:0]       idx;
    logic [NBANK*EST_W-1:0] rd_flat;

    mhc_history #(.CODE_W(CODE_W), .DEPTH(DEPTH), .MASK(MASK), .IDX_W(IDX_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .idx_o(idx), .full_o(out_valid)
    );

    mhc_table #(.IDX_W(IDX_W), .EST_W(EST_W), .NBANK(NBANK), .BSEL_W(BSEL_W)) u_tbl (
        .clk(clk), .wr_en(tw_en), .wr_bank(tw_bank), .wr_idx(tw_idx), .wr_data(tw_data),
        .rd_idx(idx), .rd_flat(rd_flat)
    );

    mhc_dither #(.CODE_W(CODE_W), .EST_W(EST_W), .NBANK(NBANK), .BSEL_W(BSEL_W)) u_dith (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .seed(seed), .mode(dmode),
        .rd_flat(rd_flat), .code_o(out_code)
    );

endmodule

// File: tb/masked_hist_corrector_bench.sv
module masked_hist_corrector_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] in_code = '0;
    logic [1:0] dmode = '0;
    logic [7:0] seed = 8'hA5;
    logic       tw_en = 1'b0;
    logic       tw_bank = 1'b0;
    logic [5:0] tw_idx = '0;
    logic [5:0] tw_data = '0;
    logic [3:0] out_code;
    logic       out_valid;

    int  n_run = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [11:0] hist_m;
    int          fill_m;
    logic [7:0]  lfsr_m;
    logic [5:0]  tbl [2][64];

    always #10 clk = ~clk;

    masked_hist_corrector u_masked_hist_corrector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
        .dmode(dmode), .seed(seed), .tw_en(tw_en), .tw_bank(tw_bank),
        .tw_idx(tw_idx), .tw_data(tw_data), .out_code(out_code), .out_valid(out_valid)
    );

    // {valid, mode[1:0], code[3:0]}
    localparam logic [6:0] VEC [0:15] = '{
        7'b1_00_1001, 7'b1_00_0011, 7'b1_00_1110, 7'b1_01_0101,
        7'b1_01_1111, 7'b0_01_0000, 7'b1_10_0110, 7'b1_10_1011,
        7'b0_10_1111, 7'b1_11_0001, 7'b1_01_1000, 7'b0_00_0111,
        7'b1_10_1101, 7'b1_10_0010, 7'b1_01_0100, 7'b1_00_1100
    };

    function automatic logic [7:0] step_m(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [5:0] cur_idx();
        return {hist_m[8], hist_m[7], hist_m[3:0]};
    endfunction

    function automatic logic [3:0] expect_code();
        logic [5:0] e;
        logic [6:0] s;
        e = tbl[(dmode == 2'd1) ? lfsr_m[0] : 1'b0][cur_idx()];
        s = 7'(e) + 7'(lfsr_m[1:0]);
        if (dmode == 2'd2) return s[6] ? 4'hF : s[5:2];
        return e[5:2];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset(input logic [7:0] s);
        hist_m = '0;
        fill_m = 0;
        lfsr_m = (s == 8'h00) ? 8'h01 : s;
    endtask

    task automatic do_reset(input logic [7:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        seed  = s;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset(s);
    endtask

    task automatic step(input logic v, input logic [3:0] c, input logic [1:0] m, input string req);
        @(negedge clk);
        in_valid = v;
        in_code  = c;
        dmode    = m;
        @(posedge clk);
        #1;
        if (v) begin
            hist_m = {hist_m[7:0], c};
            lfsr_m = step_m(lfsr_m);
            if (fill_m < 3) fill_m++;
        end
        #4;
        check({req, " code"}, int'(out_code), int'(expect_code()));
        check("R3 valid", int'(out_valid), (fill_m >= 3) ? 1 : 0);
    endtask

    task automatic write_entry(input logic b, input logic [5:0] i, input logic [5:0] d);
        @(negedge clk);
        tw_en = 1'b1; tw_bank = b; tw_idx = i; tw_data = d;
        @(posedge clk);
        #1;
        tbl[b][i] = d;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] ref_code;
        // R4: fill every entry through the write port while reset is held
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                tw_en = 1'b1; tw_bank = b[0]; tw_idx = 6'(i);
                tw_data = 6'((i * 7 + b * 29 + 5) % 64);
                tbl[b][i] = 6'((i * 7 + b * 29 + 5) % 64);
            end
        end
        @(negedge clk);
        tw_en = 1'b0;
        do_reset(8'hA5);
        #5;
        check("R3 reset valid", int'(out_valid), 0);
        check("R5 reset code", int'(out_code), int'(tbl[0][0][5:2]));

        // vector table: modes R5 R6 R7, idle samples R2, LFSR R8
        for (int k = 0; k < 16; k++) begin
            step(VEC[k][6], VEC[k][3:0], VEC[k][5:4], "R1 R2 R5 R6 R7 R8 vector");
        end

        // R1: history differing only in unmasked bits gives the same code
        step(1'b1, 4'd3, 2'd0, "R1 seq A");
        step(1'b1, 4'd5, 2'd0, "R1 seq A");
        step(1'b1, 4'd9, 2'd0, "R1 seq A");
        ref_code = out_code;
        step(1'b1, 4'd13, 2'd0, "R1 seq B");
        step(1'b1, 4'd2, 2'd0, "R1 seq B");
        step(1'b1, 4'd9, 2'd0, "R1 seq B");
        check("R1 unmasked bits ignored", int'(out_code), int'(ref_code));

        // R2: idle cycles with moving code keep the output
        step(1'b0, 4'd15, 2'd0, "R2 idle");
        check("R2 idle keeps output", int'(out_code), int'(ref_code));

        // R4: overwrite the live entry and see it immediately
        write_entry(1'b0, cur_idx(), 6'd40);
        #1;
        check("R4 write visible", int'(out_code), 10);

        // R9: mode switch with no clock edge between
        write_entry(1'b0, cur_idx(), 6'd61);
        dmode = 2'd0;
        #1;
        check("R9 stored mode", int'(out_code), 15);
        dmode = 2'd2;
        #1;
        check("R9 R7 added mode immediate", int'(out_code), int'(expect_code()));
        write_entry(1'b0, cur_idx(), 6'd63);
        #1;
        check("R7 saturate", int'(out_code), 15);
        write_entry(1'b0, cur_idx(), 6'd20);
        #1;
        check("R7 small sum", int'(out_code), int'(expect_code()));

        // R8: zero seed is replaced by 1, so random-bank mode picks bank 1 and added mode adds 1
        do_reset(8'h00);
        dmode = 2'd1;
        #5;
        check("R8 zero seed bank", int'(out_code), int'(tbl[1][0][5:2]));
        check("R3 valid after second reset", int'(out_valid), 0);
        write_entry(1'b0, 6'd0, 6'd7);
        dmode = 2'd2;
        #1;
        check("R8 zero seed dither", int'(out_code), 2);
        step(1'b1, 4'd6, 2'd1, "R6 R8 after zero seed");
        step(1'b1, 4'd1, 2'd2, "R7 R8 after zero seed");
        step(1'b1, 4'd8, 2'd3, "R5 spare mode");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule